// File: doc/BRIEF.md
# Four-Phase Valid Handshake Bus Master

This block turns single requests from a processor core into 32-bit read or write transactions on a simple memory bus. The bus uses a fully interlocked four-phase handshake. The master raises its valid line together with the address, direction, access class and write data. Memory answers by raising its own valid line. The master then withdraws its valid line, and memory withdraws its line in turn. All bus lines are sampled on rising clock edges only.

On the request side, a ready output shows when the block can accept work. One accepted request produces exactly one bus transaction. Completion is reported by a one-cycle done pulse, and read data is presented at the same time. A class flag on each request separates instruction fetches from data accesses on the bus. Writes are always marked as data accesses.

Top module: `hs_bus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_cpu_valid` and `rsp_done` are 0 and `req_ready` is 1.
- R2: A request sampled with `req_valid` and `req_ready` both high at a rising edge makes `bus_cpu_valid` go high after that edge. At the same time `bus_addr`, `bus_rw` and `bus_wdata` take the values of the request.
- R3: While `bus_cpu_valid` stays high, `bus_addr`, `bus_rw`, `bus_inst_data` and `bus_wdata` do not change.
- R4: `bus_cpu_valid` stays high until `bus_mem_valid` has been sampled high at a rising edge. It goes low right after the first such edge.
- R5: For a read, `rsp_rdata` takes the value on `bus_rdata` at the first edge where `bus_mem_valid` is sampled high. The value is valid while `rsp_done` is high.
- R6: After `bus_cpu_valid` falls, it is not raised again until `bus_mem_valid` has been sampled low at a rising edge.
- R7: `bus_rw` is 1 for a write and 0 for a read. `bus_inst_data` is 0 for a fetch (`req_is_data`=0) and 1 for a data access. For a write it is 1 whatever `req_is_data` holds.
- R8: `req_ready` is 0 from acceptance until the handshake has fully completed. A `req_valid` raised while `req_ready` is 0 starts no transaction.
- R9: `rsp_done` is high for exactly one cycle per transaction. That cycle directly follows the edge where `bus_mem_valid` was first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_done |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_inst_data | output | 1 | 0 = fetch, 1 = data access |
| bus_rw | output | 1 | 0 = read, 1 = write |
| bus_cpu_valid | output | 1 | Master valid |
| bus_mem_valid | input | 1 | Memory valid |
| bus_rdata | input | DW | Data driven by memory |

## Verification
The bench memory answers and releases after random delays, including zero. A master that sampled a stale response, dropped its valid line early or held it one cycle too long would break the edge-by-edge handshake checks. When memory is not driving, the bench puts a poison word on the data lines, so read data captured at the wrong edge shows up as a mismatch. Requests are pushed while the block is busy, and a design that accepted them would put an unexpected transaction on the bus. Writes marked as fetches catch a class line that is passed through without being forced to data. A read-back after each write catches write data that never reached memory.

// File: rtl/hs_bus_master.sv
module hs_bus_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_is_data,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_inst_data,
  output logic          bus_rw,
  output logic          bus_cpu_valid,
  input  logic          bus_mem_valid,
  input  logic [DW-1:0] bus_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RELEASE} state_t;
  state_t state;

  assign req_ready     = (state == S_IDLE);
  assign bus_cpu_valid = (state == S_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      rsp_done      <= 1'b0;
      rsp_rdata     <= '0;
      bus_addr      <= '0;
      bus_wdata     <= '0;
      bus_rw        <= 1'b0;
      bus_inst_data <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          bus_addr      <= req_addr;
          bus_wdata     <= req_wdata;
          bus_rw        <= req_write;
          bus_inst_data <= req_write | req_is_data;
          state         <= S_REQ;
        end
        S_REQ: if (bus_mem_valid) begin
          if (!bus_rw) rsp_rdata <= bus_rdata;
          rsp_done <= 1'b1;
          state    <= S_RELEASE;
        end
        S_RELEASE: if (!bus_mem_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs_bus_master_chk.sv
module hs_bus_master_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_done,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_inst_data,
  input logic          bus_rw,
  input logic          bus_cpu_valid,
  input logic          bus_mem_valid
);

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> bus_cpu_valid && bus_addr == $past(req_addr));

  p_hold_fields_r3: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid |=> !bus_cpu_valid ||
      ($stable(bus_addr) && $stable(bus_rw) && $stable(bus_inst_data) && $stable(bus_wdata)));

  p_wait_ack_r4: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && !bus_mem_valid |=> bus_cpu_valid);

  p_drop_on_ack_r4: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && bus_mem_valid |=> !bus_cpu_valid);

  p_wait_release_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_cpu_valid && bus_mem_valid |=> !bus_cpu_valid);

  p_write_is_data_r7: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && bus_rw |-> bus_inst_data);

  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid |-> !req_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

bind hs_bus_master hs_bus_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_done(rsp_done), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_inst_data(bus_inst_data), .bus_rw(bus_rw),
  .bus_cpu_valid(bus_cpu_valid), .bus_mem_valid(bus_mem_valid)
);

// File: tb/hs_bus_master_bench.sv
module hs_bus_master_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_is_data = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_done, bus_inst_data, bus_rw, bus_cpu_valid;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata, bus_rdata;
  logic        bus_mem_valid;

  hs_bus_master u_hs_bus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_is_data(req_is_data), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_inst_data(bus_inst_data),
    .bus_rw(bus_rw), .bus_cpu_valid(bus_cpu_valid),
    .bus_mem_valid(bus_mem_valid), .bus_rdata(bus_rdata));

  int errors = 0, checks = 0, issued = 0, dones = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input int i);
    return 32'h1000_0000 + i * 32'h0101_0101;
  endfunction

  // memory model with random answer and release delays
  logic [31:0] mem [16];
  logic [31:0] mem_rd;
  logic        mv = 1'b0;
  int          mst = 0, mcnt = 0;
  assign bus_mem_valid = mv;
  assign bus_rdata = mv ? mem_rd : 32'hDEAD_BEEF;

  initial for (int i = 0; i < 16; i++) mem[i] = init_word(i);

  always @(posedge clk) begin
    if (rst) begin
      mv <= 1'b0; mst <= 0;
    end else begin
      case (mst)
        0: if (bus_cpu_valid) begin
             automatic int lat = $urandom_range(0, 4);
             if (bus_rw) mem[bus_addr[5:2]] <= bus_wdata;
             mem_rd <= mem[bus_addr[5:2]];
             if (lat == 0) begin mv <= 1'b1; mst <= 2; end
             else begin mcnt <= lat; mst <= 1; end
           end
        1: if (mcnt == 1) begin mv <= 1'b1; mst <= 2; end else mcnt <= mcnt - 1;
        2: if (!bus_cpu_valid) begin
             automatic int rel = $urandom_range(0, 3);
             if (rel == 0) begin mv <= 1'b0; mst <= 0; end
             else begin mcnt <= rel; mst <= 3; end
           end
        default: if (mcnt == 1) begin mv <= 1'b0; mst <= 0; end else mcnt <= mcnt - 1;
      endcase
    end
  end

  // scoreboard
  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        write;
    logic        inst;
    logic [31:0] rdata;
  } item_t;
  item_t exp_q[$];
  logic [31:0] ref_mem [16];
  initial for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);

  task automatic issue(input logic [31:0] a, input logic [31:0] d, input bit w, input bit isd);
    item_t it;
    while (!req_ready) @(negedge clk);
    req_addr = a; req_wdata = d; req_write = w; req_is_data = isd; req_valid = 1'b1;
    it.addr = a; it.wdata = d; it.write = w; it.inst = w | isd;
    it.rdata = ref_mem[a[5:2]];
    if (w) ref_mem[a[5:2]] = d;
    exp_q.push_back(it);
    issued++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  logic pcv = 1'b0, pmv = 1'b0;
  logic [31:0] paddr = '0, pwd = '0;
  logic prw = 1'b0, pinst = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      pcv <= 1'b0; pmv <= 1'b0;
    end else begin
      if (bus_cpu_valid && !pcv) begin
        if (exp_q.size() == 0)
          check(1'b0, "R8 transaction without accepted request", bus_addr, 32'h0);
        else begin
          check(bus_addr == exp_q[0].addr, "R2 address", bus_addr, exp_q[0].addr);
          check(bus_rw == exp_q[0].write, "R7 rw", {31'b0, bus_rw}, {31'b0, exp_q[0].write});
          check(bus_inst_data == exp_q[0].inst, "R7 inst_data", {31'b0, bus_inst_data}, {31'b0, exp_q[0].inst});
          if (exp_q[0].write)
            check(bus_wdata == exp_q[0].wdata, "R2 write data", bus_wdata, exp_q[0].wdata);
        end
        if (pmv) check(1'b0, "R6 valid raised before memory released", 32'h1, 32'h0);
      end
      if (bus_cpu_valid && pcv)
        check(bus_addr == paddr && bus_wdata == pwd && bus_rw == prw && bus_inst_data == pinst,
              "R3 fields stable", bus_addr, paddr);
      if (pcv && pmv) check(!bus_cpu_valid, "R4 drop after ack", {31'b0, bus_cpu_valid}, 32'h0);
      if (pcv && !pmv) check(bus_cpu_valid, "R4 hold until ack", {31'b0, bus_cpu_valid}, 32'h1);
      if (bus_cpu_valid) check(!req_ready, "R8 ready low while busy", {31'b0, req_ready}, 32'h0);
      if (rsp_done || (pcv && pmv))
        check(rsp_done == (pcv && pmv), "R9 done timing", {31'b0, rsp_done}, {31'b0, pcv && pmv});
      if (rsp_done) begin
        dones++;
        if (exp_q.size() != 0) begin
          if (!exp_q[0].write)
            check(rsp_rdata == exp_q[0].rdata, "R5 read data", rsp_rdata, exp_q[0].rdata);
          void'(exp_q.pop_front());
        end
      end
      pcv <= bus_cpu_valid; pmv <= bus_mem_valid;
      paddr <= bus_addr; pwd <= bus_wdata; prw <= bus_rw; pinst <= bus_inst_data;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_cpu_valid, "R1 valid low in reset", {31'b0, bus_cpu_valid}, 32'h0);
    check(req_ready, "R1 ready in reset", {31'b0, req_ready}, 32'h1);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_cpu_valid && !rsp_done && req_ready, "R1 state after reset",
          {29'b0, bus_cpu_valid, rsp_done, req_ready}, 32'h1);

    issue(32'h0000_0004, 32'h0, 1'b0, 1'b0);   // fetch
    issue(32'h0000_0008, 32'h0, 1'b0, 1'b1);   // data read
    issue(32'h0000_0010, 32'hCAFE_0001, 1'b1, 1'b1);
    issue(32'h0000_0010, 32'h0, 1'b0, 1'b1);   // read-back
    issue(32'h0000_0020, 32'h1234_5678, 1'b1, 1'b0); // write tagged fetch -> data
    issue(32'h0000_0020, 32'h0, 1'b0, 1'b0);

    // requests raised while busy must be ignored (R8)
    issue(32'h0000_0030, 32'h0, 1'b0, 1'b1);
    req_addr = 32'h0000_003C; req_write = 1'b1; req_wdata = 32'hBAD0_BAD0; req_valid = 1'b1;
    check(!req_ready, "R8 ready low after accept", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    check(!req_ready, "R8 ready low second busy cycle", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    issue(32'h0000_003C, 32'h0, 1'b0, 1'b1);   // location untouched by ignored write

    for (int n = 0; n < 40; n++)
      issue({26'b0, 4'($urandom_range(0, 15)), 2'b00}, $urandom, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)));

    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check(dones == issued, "R9 one done per request", dones, issued);
    finish_run();
  end
endmodule